// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits beside the register bus of a cipher-style peripheral and watches every access. It sorts misuse into typed software errors with a warning or error class. It also raises a write-protect flag when a guarded register is written while protection is on. Three hazard inputs are sticky as well: an internal sequencer fault, a detected clock glitch and a private-key bus violation. All of these collect in one read-only status word at offset 0xE8.

Every flag in the status word holds until software reads the word. That read returns the value as it stood and clears the flags at the next clock edge. A one-bit protection register at offset 0xE4 arms write protection over the two mode registers and the init-value bank. The monitor decodes only one data bit, bit 0 of the write data. That bit is START for the control register and the protection enable for the protection register. The cipher datapath, the DMA engine and the glitch detector lie outside this block.

The register map is fixed, and every offset is word aligned (the two low bits are 00):

| Register | Offset | Access |
|---|---|---|
| control | 0x00 | write-only |
| mode | 0x04, 0x08 | read/write, guarded |
| status | 0x0C | read-only |
| key bank | 0x10 to 0x1C | write-only |
| input-data bank | 0x20 to 0x2C | write-only |
| output-data bank | 0x30 to 0x3C | read-only |
| init-value bank | 0x40 to 0x4C | write-only, guarded |
| protection | 0xE4 | read/write |
| violation status | 0xE8 | read-only |

Every other offset is undefined.

Top module: `regAccessMonitor`

## Requirements
- R1: After reset the status word at 0xE8 reads 0x00000000 and the protection register at 0xE4 reads 0.
- R2: Status word layout: bit 31 error class (1 = error), bits 27:24 software error type, bits 15:8 source offset, bit 4 private-key violation, bit 3 software error, bit 2 sequencer fault, bit 1 clock glitch, bit 0 write-protect violation. Every other bit reads 0.
- R3: A read of a write-only register (control, key bank, input-data bank, init-value bank) sets the software error bit with type 0, class warning and source = the offset read.
- R4: A write to a read-only register (0x0C, 0x30 to 0x3C, 0xE8) sets type 1 with class warning while `enabled` is 1. The same write has no effect while `enabled` is 0.
- R5: A read or write at an undefined offset, including any offset that is not word aligned, sets type 2 with class warning.
- R6: A write to 0x00 with `wrBit` = 1 (START) is checked in this order. With `busy` high it sets type 4, class error. Otherwise, with `keyComplete` low it sets type 5, class error. Otherwise, with `dmaMode` high it sets type 3, class warning. A write with `wrBit` = 0 while idle raises nothing.
- R7: While `busy` is 1, a write to the control, mode, key, input-data or init-value registers, or a read of the output-data bank, sets type 4 with class error. The same accesses while idle raise nothing.
- R8: While the protection register holds 1, a write to 0x04, 0x08 or 0x40 to 0x4C drives `writeBlocked` high in that cycle. It also sets bit 0 with source = that offset, and it raises no software error. With protection at 0 the same write is not blocked.
- R9: Once bit 0 is set, later software errors do not change the source field, and a write-protect violation always overwrites it.
- R10: A one-cycle pulse on `seqFault`, `clkGlitch` or `pkViolation` sets bit 2, bit 1 or bit 4 respectively, and the bit holds.
- R11: A read of 0xE8 returns the pre-clear value in the same cycle. Class, type and all flag bits are zero from the next cycle on. The source field keeps its value.
- R12: With several software errors before a read, the latest type and source are kept, and the class bit stays 1 once any of them was an error.
- R13: An event in the same cycle as the clearing read is kept and appears on the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the current access |
| busWr | input | 1 | Write strobe; a write takes precedence over a read in the same cycle |
| busRd | input | 1 | Read strobe |
| wrBit | input | 1 | Bit 0 of the write data |
| enabled | input | 1 | Peripheral enabled |
| busy | input | 1 | Encryption or decryption in progress |
| dmaMode | input | 1 | DMA transfer mode configured |
| keyComplete | input | 1 | All key words loaded |
| seqFault | input | 1 | Internal sequencer fault pulse |
| clkGlitch | input | 1 | Clock glitch detection pulse |
| pkViolation | input | 1 | Private-key bus violation pulse |
| rdData | output | 32 | Read data for 0xE8 and 0xE4; zero otherwise |
| writeBlocked | output | 1 | The current write hits a guarded register and is suppressed |

## Verification
The hardest case to reach is a new event that lands in the very cycle of the clearing read. The monitor takes one bus access per cycle, so no second software error can arrive beside the read. The bench therefore raises a sequencer-fault pulse during the status read strobe. It expects the pre-clear word at that read and the fault bit alone on the next read. A second hard case is a mix of write-protect and software-error sources before a read. The bench gets there by arming protection through 0xE4 and then interleaving guarded writes with bad reads in both orders.

// File: rtl/ramPkg.sv
package ramPkg;

  localparam int OFS_W      = 8;
  localparam int STAT_W     = 32;
  localparam int BANK_WORDS = 4;

  localparam logic [OFS_W-1:0] CTRL_OFS  = 8'h00;
  localparam logic [OFS_W-1:0] MODE_OFS  = 8'h04;
  localparam logic [OFS_W-1:0] XMODE_OFS = 8'h08;
  localparam logic [OFS_W-1:0] STAT_OFS  = 8'h0C;
  localparam logic [OFS_W-1:0] KEY_BASE  = 8'h10;
  localparam logic [OFS_W-1:0] DIN_BASE  = 8'h20;
  localparam logic [OFS_W-1:0] DOUT_BASE = 8'h30;
  localparam logic [OFS_W-1:0] IV_BASE   = 8'h40;
  localparam logic [OFS_W-1:0] PROT_OFS  = 8'hE4;
  localparam logic [OFS_W-1:0] WSTAT_OFS = 8'hE8;

  typedef enum logic [3:0] {
    RK_NONE, RK_CTRL, RK_MODE, RK_STAT, RK_KEY,
    RK_DIN, RK_DOUT, RK_IV, RK_PROT, RK_WSTAT
  } regKind_e;

  typedef enum logic [3:0] {
    SW_READ_WO     = 4'd0,
    SW_WRITE_RO    = 4'd1,
    SW_UNDEF       = 4'd2,
    SW_START_DMA   = 4'd3,
    SW_BUSY_ACCESS = 4'd4,
    SW_KEY_PARTIAL = 4'd5
  } swType_e;

  // Strobes from the access control to the status datapath
  typedef struct packed {
    logic             wpEvt;
    logic             swEvt;
    swType_e          swType;
    logic             swErr;
    logic             clrRd;
    logic             rdProt;
    logic             protWr;
    logic             protVal;
    logic [OFS_W-1:0] srcOfs;
  } strobes_t;

  function automatic logic inBank(input logic [OFS_W-1:0] a, input logic [OFS_W-1:0] base);
    return (a >= base) && ({1'b0, a} < ({1'b0, base} + (OFS_W+1)'(4 * BANK_WORDS)));
  endfunction

  function automatic regKind_e decodeOfs(input logic [OFS_W-1:0] a);
    regKind_e k;
    k = RK_NONE;
    if (a[1:0] == 2'b00) begin
      if (a == CTRL_OFS)                         k = RK_CTRL;
      else if (a == MODE_OFS || a == XMODE_OFS)  k = RK_MODE;
      else if (a == STAT_OFS)                    k = RK_STAT;
      else if (inBank(a, KEY_BASE))              k = RK_KEY;
      else if (inBank(a, DIN_BASE))              k = RK_DIN;
      else if (inBank(a, DOUT_BASE))             k = RK_DOUT;
      else if (inBank(a, IV_BASE))               k = RK_IV;
      else if (a == PROT_OFS)                    k = RK_PROT;
      else if (a == WSTAT_OFS)                   k = RK_WSTAT;
    end
    return k;
  endfunction

  function automatic logic isReadable(input regKind_e k);
    return (k == RK_MODE) || (k == RK_STAT) || (k == RK_DOUT) ||
           (k == RK_PROT) || (k == RK_WSTAT);
  endfunction

  function automatic logic isWritable(input regKind_e k);
    return (k == RK_CTRL) || (k == RK_MODE) || (k == RK_KEY) ||
           (k == RK_DIN) || (k == RK_IV) || (k == RK_PROT);
  endfunction

  function automatic logic isGuarded(input regKind_e k);
    return (k == RK_MODE) || (k == RK_IV);
  endfunction

  function automatic logic isBusyWriteBad(input regKind_e k);
    return (k == RK_CTRL) || (k == RK_MODE) || (k == RK_KEY) ||
           (k == RK_DIN) || (k == RK_IV);
  endfunction

endpackage

// File: rtl/ramAccessCtrl.sv
module ramAccessCtrl
  import ramPkg::*;
(
  input  logic             busWr,
  input  logic             busRd,
  input  logic [OFS_W-1:0] busAddr,
  input  logic             wrBit,
  input  logic             enabled,
  input  logic             busy,
  input  logic             dmaMode,
  input  logic             keyComplete,
  input  logic             protEn,
  output strobes_t         stb
);

  regKind_e kind;
  logic     rdAcc;

  assign kind  = decodeOfs(busAddr);
  assign rdAcc = busRd && !busWr;

  always_comb begin
    stb        = '0;
    stb.swType = SW_READ_WO;
    stb.srcOfs = busAddr;
    if (busWr) begin
      if (kind == RK_NONE) begin
        stb.swEvt  = 1'b1;
        stb.swType = SW_UNDEF;
      end else if (protEn && isGuarded(kind)) begin
        stb.wpEvt = 1'b1;
      end else if (!isWritable(kind)) begin
        if (enabled) begin
          stb.swEvt  = 1'b1;
          stb.swType = SW_WRITE_RO;
        end
      end else if (busy && isBusyWriteBad(kind)) begin
        stb.swEvt  = 1'b1;
        stb.swType = SW_BUSY_ACCESS;
        stb.swErr  = 1'b1;
      end else if (kind == RK_CTRL && wrBit) begin
        if (!keyComplete) begin
          stb.swEvt  = 1'b1;
          stb.swType = SW_KEY_PARTIAL;
          stb.swErr  = 1'b1;
        end else if (dmaMode) begin
          stb.swEvt  = 1'b1;
          stb.swType = SW_START_DMA;
        end
      end
      if (kind == RK_PROT) begin
        stb.protWr  = 1'b1;
        stb.protVal = wrBit;
      end
    end else if (rdAcc) begin
      if (kind == RK_NONE) begin
        stb.swEvt  = 1'b1;
        stb.swType = SW_UNDEF;
      end else if (!isReadable(kind)) begin
        stb.swEvt  = 1'b1;
        stb.swType = SW_READ_WO;
      end else if (kind == RK_DOUT && busy) begin
        stb.swEvt  = 1'b1;
        stb.swType = SW_BUSY_ACCESS;
        stb.swErr  = 1'b1;
      end
      stb.clrRd  = (kind == RK_WSTAT);
      stb.rdProt = (kind == RK_PROT);
    end
  end

endmodule

// File: rtl/ramStatusPath.sv
module ramStatusPath
  import ramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              seqFault,
  input  logic              clkGlitch,
  input  logic              pkViolation,
  output logic              protEn,
  output logic [STAT_W-1:0] statusWord,
  output logic [STAT_W-1:0] rdData
);

  logic             clsQ, pkQ, sweQ, seqQ, cgdQ, wpvQ, protQ;
  swType_e          typQ;
  logic [OFS_W-1:0] srcQ;
  logic             keep;

  assign keep = !stb.clrRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsQ  <= 1'b0;
      typQ  <= SW_READ_WO;
      srcQ  <= '0;
      pkQ   <= 1'b0;
      sweQ  <= 1'b0;
      seqQ  <= 1'b0;
      cgdQ  <= 1'b0;
      wpvQ  <= 1'b0;
      protQ <= 1'b0;
    end else begin
      wpvQ <= (keep && wpvQ) || stb.wpEvt;
      sweQ <= (keep && sweQ) || stb.swEvt;
      seqQ <= (keep && seqQ) || seqFault;
      cgdQ <= (keep && cgdQ) || clkGlitch;
      pkQ  <= (keep && pkQ)  || pkViolation;
      clsQ <= (keep && clsQ) || (stb.swEvt && stb.swErr);
      if (stb.swEvt)      typQ <= stb.swType;
      else if (stb.clrRd) typQ <= SW_READ_WO;
      if (stb.wpEvt)                           srcQ <= stb.srcOfs;
      else if (stb.swEvt && !(keep && wpvQ))   srcQ <= stb.srcOfs;
      if (stb.protWr) protQ <= stb.protVal;
    end
  end

  assign protEn     = protQ;
  assign statusWord = {clsQ, 3'b000, typQ, 8'h00, srcQ, 3'b000, pkQ, sweQ, seqQ, cgdQ, wpvQ};
  assign rdData     = stb.clrRd  ? statusWord :
                      stb.rdProt ? {{(STAT_W-1){1'b0}}, protQ} : '0;

endmodule

// File: rtl/regAccessMonitor.sv
module regAccessMonitor
  import ramPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        wrBit,
  input  logic        enabled,
  input  logic        busy,
  input  logic        dmaMode,
  input  logic        keyComplete,
  input  logic        seqFault,
  input  logic        clkGlitch,
  input  logic        pkViolation,
  output logic [31:0] rdData,
  output logic        writeBlocked
);

  strobes_t          stb;
  logic              protEn;
  logic [STAT_W-1:0] statusWord;

  ramAccessCtrl u_ctrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .wrBit(wrBit),
    .enabled(enabled), .busy(busy), .dmaMode(dmaMode),
    .keyComplete(keyComplete), .protEn(protEn), .stb(stb)
  );

  ramStatusPath u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .seqFault(seqFault),
    .clkGlitch(clkGlitch), .pkViolation(pkViolation), .protEn(protEn),
    .statusWord(statusWord), .rdData(rdData)
  );

  assign writeBlocked = stb.wpEvt;

endmodule

// File: rtl/regAccessMonitorChk.sv
module regAccessMonitorChk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busWr,
  input logic        busRd,
  input logic        seqFault,
  input logic        clkGlitch,
  input logic        pkViolation,
  input logic        writeBlocked,
  input logic [31:0] statusWord
);

  logic clearRead;
  assign clearRead = busRd && !busWr && (busAddr == 8'hE8);

  // R2: unused status bits stay zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[30:28] == 3'b000) && (statusWord[23:16] == 8'h00) && (statusWord[7:5] == 3'b000));

  // R8: blocking only happens on a write
  a_r8_block_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    writeBlocked |-> busWr);

  // R8: a blocked write records flag and offset
  a_r8_flag_and_source: assert property (@(posedge clk) disable iff (!rstN)
    writeBlocked |=> (statusWord[0] && (statusWord[15:8] == $past(busAddr))));

  // R9: source held while a write-protect violation is pending
  a_r9_source_hold: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && !writeBlocked) |=> $stable(statusWord[15:8]));

  // R10: hazard pulses are captured
  a_r10_seq_capture: assert property (@(posedge clk) disable iff (!rstN)
    seqFault |=> statusWord[2]);
  a_r10_glitch_capture: assert property (@(posedge clk) disable iff (!rstN)
    clkGlitch |=> statusWord[1]);
  a_r10_pk_capture: assert property (@(posedge clk) disable iff (!rstN)
    pkViolation |=> statusWord[4]);

  // R11: a clearing read with no hazard clears the hazard flags
  a_r11_clear_hazards: assert property (@(posedge clk) disable iff (!rstN)
    (clearRead && !seqFault && !clkGlitch && !pkViolation) |=>
      (!statusWord[4] && !statusWord[2] && !statusWord[1]));

  // R12: error class holds until a clearing read
  a_r12_class_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[31] && !clearRead) |=> statusWord[31]);

endmodule

bind regAccessMonitor regAccessMonitorChk chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .seqFault(seqFault), .clkGlitch(clkGlitch), .pkViolation(pkViolation),
  .writeBlocked(writeBlocked), .statusWord(statusWord)
);

// File: tb/tb_regAccessMonitor.sv
`timescale 1ns/1ps
module tb_regAccessMonitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0, wrBit = 1'b0;
  logic        enabled = 1'b1, busy = 1'b0, dmaMode = 1'b0, keyComplete = 1'b1;
  logic        seqFault = 1'b0, clkGlitch = 1'b0, pkViolation = 1'b0;
  logic [31:0] rdData;
  logic        writeBlocked;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  regAccessMonitor dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .wrBit(wrBit), .enabled(enabled), .busy(busy), .dmaMode(dmaMode),
    .keyComplete(keyComplete), .seqFault(seqFault), .clkGlitch(clkGlitch),
    .pkViolation(pkViolation), .rdData(rdData), .writeBlocked(writeBlocked)
  );

  // {wr, rd, addr[7:0], wrBit, enabled, busy, dmaMode, keyComplete, expected[31:0]}
  localparam int NVEC = 17;
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_1008}, // R3
    {1'b0, 1'b1, 8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_4408}, // R3
    {1'b1, 1'b0, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0100_3008}, // R4
    {1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_3000}, // R4
    {1'b1, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_8008}, // R5
    {1'b0, 1'b1, 8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_9008}, // R5
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0300_0008}, // R6
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8500_0008}, // R6
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h8400_0008}, // R6
    {1'b1, 1'b0, 8'h14, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8400_1408}, // R7
    {1'b0, 1'b1, 8'h38, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8400_3808}, // R7
    {1'b1, 1'b0, 8'h04, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8400_0408}, // R7
    {1'b1, 1'b0, 8'h24, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h8400_2408}, // R7
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_2400}, // R6
    {1'b1, 1'b0, 8'h14, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2400}, // R7
    {1'b0, 1'b1, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2400}, // R7
    {1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0200_1108}  // R5
  };

  function automatic string tagOf(input int i);
    case (i)
      0, 1:                 return "R3";
      2, 3:                 return "R4";
      4, 5, 16:             return "R5";
      6, 7, 8, 13:          return "R6";
      default:              return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic doAccess(input logic wr, input logic rd, input logic [7:0] a, input logic b);
    busWr = wr; busRd = rd; busAddr = a; wrBit = b;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; busAddr = '0; wrBit = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    busRd = 1'b1; busAddr = a;
    #1 v = rdData;
    @(negedge clk);
    busRd = 1'b0; busAddr = '0;
  endtask

  task automatic wrSample(input logic [7:0] a, output logic blk);
    busWr = 1'b1; busAddr = a; wrBit = 1'b0;
    #1 blk = writeBlocked;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic blk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(8'hE8, v); check("R1 status after reset", v, 32'h0);
    readReg(8'hE4, v); check("R1 protection after reset", v, 32'h0);

    // Vector table: one access, then a clearing status read
    for (int i = 0; i < NVEC; i++) begin
      enabled = VEC[i][35]; busy = VEC[i][34]; dmaMode = VEC[i][33]; keyComplete = VEC[i][32];
      doAccess(VEC[i][46], VEC[i][45], VEC[i][44:37], VEC[i][36]);
      enabled = 1'b1; busy = 1'b0; dmaMode = 1'b0; keyComplete = 1'b1;
      readReg(8'hE8, v);
      check($sformatf("%s table vector %0d", tagOf(i), i), v, VEC[i][31:0]);
    end

    // R8: arm protection, guarded write is blocked
    doAccess(1'b1, 1'b0, 8'hE4, 1'b1);
    readReg(8'hE4, v); check("R8 protection readback", v, 32'h1);
    wrSample(8'h08, blk); check("R8 writeBlocked on guarded write", {31'b0, blk}, 32'h1);
    readReg(8'hE8, v); check("R8 write-protect flag and source", v, 32'h0000_0801);
    busy = 1'b1;
    wrSample(8'h08, blk);
    busy = 1'b0;
    readReg(8'hE8, v); check("R8 blocked write while busy raises no software error", v, 32'h0000_0801);

    // R9: write-protect source wins in both orders; R2 field positions
    doAccess(1'b1, 1'b0, 8'h44, 1'b0);
    doAccess(1'b0, 1'b1, 8'h10, 1'b0);
    readReg(8'hE8, v); check("R9 R2 protect then software error", v, 32'h0000_4409);
    doAccess(1'b0, 1'b1, 8'h10, 1'b0);
    doAccess(1'b1, 1'b0, 8'h48, 1'b0);
    readReg(8'hE8, v); check("R9 software error then protect", v, 32'h0000_4809);

    // R8: disarmed protection does not block
    doAccess(1'b1, 1'b0, 8'hE4, 1'b0);
    wrSample(8'h08, blk); check("R8 no block when disarmed", {31'b0, blk}, 32'h0);
    readReg(8'hE8, v); check("R8 no flag when disarmed", v, 32'h0000_4800);

    // R11: pre-clear value, then cleared with source kept
    doAccess(1'b0, 1'b1, 8'h10, 1'b0);
    readReg(8'hE8, v); check("R11 first read returns event", v, 32'h0000_1008);
    readReg(8'hE8, v); check("R11 second read cleared", v, 32'h0000_1000);

    // R12: latest type and source, class stays error
    busy = 1'b1;
    doAccess(1'b1, 1'b0, 8'h14, 1'b0);
    busy = 1'b0;
    doAccess(1'b0, 1'b1, 8'h20, 1'b0);
    readReg(8'hE8, v); check("R12 latest type with sticky class", v, 32'h8000_2008);

    // R10: hazard pulses
    seqFault = 1'b1; @(negedge clk); seqFault = 1'b0;
    repeat (2) @(negedge clk);
    clkGlitch = 1'b1; pkViolation = 1'b1; @(negedge clk);
    clkGlitch = 1'b0; pkViolation = 1'b0;
    readReg(8'hE8, v); check("R10 hazard flags sticky", v, 32'h0000_2016);

    // R13: event during the clearing read
    seqFault = 1'b1;
    readReg(8'hE8, v);
    seqFault = 1'b0;
    check("R13 read during event shows pre-clear value", v, 32'h0000_2000);
    readReg(8'hE8, v); check("R13 event kept for next read", v, 32'h0000_2004);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule